// File: doc/BRIEF.md
# CRC-8 Fold Accumulator

This block turns a stream of up to eight bytes per beat into a 16-bit partial remainder for the CRC-8 with generator x^8+x^2+x+1 (0x107). There is no bit-serial shift register. Each byte lane is multiplied without carries by a constant x^(8j) mod P, where j counts the byte positions that follow that byte within the beat. The running fold from earlier beats is handled as a two-byte prefix: its high and low bytes are multiplied by the constants for the position just past the beat. The XOR of all these products becomes the new fold. One beat is absorbed on each clock.

When the beat marked last has been absorbed, the block presents the fold value together with a one-cycle done strobe. It then clears the running value so the next message starts from zero. The fold F stands for the CRC in the sense CRC = (F · x^8) mod P. A separate reducer, outside this block, produces the final 8-bit value. The CRC convention is initial value zero, no reflection and no output XOR.

Top module: `crc8_fold_acc`

## Requirements
- R1: After reset is asserted, fold_o is 0 and done_o is 0.
- R2: Byte lane k occupies beat_data_i bits [8k+7:8k], and lane 0 is the first byte of the message. A single full last beat of bytes 31 32 33 34 35 36 37 38 yields fold_o = 0x1137.
- R3: done_o is high in exactly the cycle after each clock edge at which a beat with beat_valid_i and beat_last_i is accepted, and is low at all other times.
- R4: fold_o changes only together with a done_o pulse and holds its value between pulses.
- R5: For a message sent as beats with counts between 1 and 8, (fold_o · x^8) mod 0x107 equals the bit-serial CRC-8 of the concatenated bytes. For example, bytes 05 07 give 0x54, and bytes 31..38 split as 5 then 3 give 0xC7.
- R6: In a beat with count n, lanes n and above do not affect the result.
- R7: A beat with count 0 appends no byte, so the CRC is unchanged. A count above 8 is treated as 8.
- R8: Input with beat_valid_i low, including beat_last_i or data values, has no effect.
- R9: After a last beat the running value restarts from zero, so consecutive messages are independent.
- R10: A single-beat message of one byte b gives fold_o = {8'h00, b}. A message of only zero bytes gives fold_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | Beat present this cycle |
| beat_last_i | input | 1 | Beat closes the message |
| beat_count_i | input | 4 | Number of valid byte lanes, from lane 0 upward |
| beat_data_i | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| fold_o | output | 16 | Folded 16-bit remainder of the last finished message |
| done_o | output | 1 | One-cycle strobe: fold_o is new |

## Verification
The bench fills the lanes above the count with garbage. A design that skipped the lane masking, or that picked constants by lane index instead of by the count, would then corrupt short beats. Count 0 and counts above eight are driven directly: a wrong clamp or a wrong carry constant would shift the CRC. Idle cycles with beat_last_i high and junk data catch a design that gates on last without valid. Back-to-back messages expose a running value that is not cleared. Random messages of 1 to 40 bytes, split at random points, are reduced and compared with a bit-serial model, so any wrong carry-in constant shows up as a mismatch.

// File: rtl/crc8_fold_pkg.sv
package crc8_fold_pkg;

  typedef logic [15:0] fold_t;

  // 8x8 carryless product
  function automatic fold_t clmul8(input logic [7:0] a, input logic [7:0] b);
    fold_t p;
    p = '0;
    for (int i = 0; i < 8; i++) begin
      if (a[i]) p = p ^ (fold_t'(b) << i);
    end
    return p;
  endfunction

  // x^(8*j) mod poly
  function automatic logic [7:0] pow_x8(input int j, input logic [8:0] poly);
    logic [8:0] d;
    d = 9'd1;
    for (int i = 0; i < 8 * j; i++) begin
      d = d << 1;
      if (d[8]) d = d ^ poly;
    end
    return d[7:0];
  endfunction

endpackage

// File: rtl/crc8_fold_lane.sv
module crc8_fold_lane #(
  parameter int         LANES = 8,
  parameter int         LANE  = 0,
  parameter logic [8:0] POLY  = 9'h107,
  localparam int        CW    = $clog2(LANES + 1)
) (
  input  logic [CW-1:0]             count_i,
  input  logic [7:0]                byte_i,
  output crc8_fold_pkg::fold_t      prod_o
);
  logic [7:0] kc [LANES];
  logic [7:0] k_sel;

  for (genvar j = 0; j < LANES; j++) begin : g_k
    localparam logic [7:0] KV = crc8_fold_pkg::pow_x8(j, POLY);
    assign kc[j] = KV;
  end

  // byte followed by j more bytes in this beat uses x^(8j)
  always_comb begin
    k_sel = '0;
    for (int j = 0; j < LANES; j++) begin
      if (int'(count_i) == LANE + 1 + j) k_sel = kc[j];
    end
  end

  assign prod_o = crc8_fold_pkg::clmul8(byte_i, k_sel);
endmodule

// File: rtl/crc8_fold_carry.sv
module crc8_fold_carry #(
  parameter int         LANES = 8,
  parameter logic [8:0] POLY  = 9'h107,
  localparam int        CW    = $clog2(LANES + 1)
) (
  input  logic [CW-1:0]        count_i,
  input  crc8_fold_pkg::fold_t fold_i,
  output crc8_fold_pkg::fold_t prod_o
);
  logic [7:0] kc [LANES + 2];
  logic [7:0] k_hi, k_lo;

  for (genvar j = 0; j < LANES + 2; j++) begin : g_k
    localparam logic [7:0] KV = crc8_fold_pkg::pow_x8(j, POLY);
    assign kc[j] = KV;
  end

  // prior fold is a two-byte prefix shifted past count bytes
  always_comb begin
    k_hi = kc[1];
    k_lo = kc[0];
    for (int j = 0; j <= LANES; j++) begin
      if (int'(count_i) == j) begin
        k_hi = kc[j + 1];
        k_lo = kc[j];
      end
    end
  end

  assign prod_o = crc8_fold_pkg::clmul8(fold_i[15:8], k_hi)
                ^ crc8_fold_pkg::clmul8(fold_i[7:0], k_lo);
endmodule

// File: rtl/crc8_fold_acc.sv
module crc8_fold_acc #(
  parameter int         LANES = 8,
  parameter logic [8:0] POLY  = 9'h107,
  localparam int        CW    = $clog2(LANES + 1),
  localparam int        DW    = 8 * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_valid_i,
  input  logic          beat_last_i,
  input  logic [CW-1:0] beat_count_i,
  input  logic [DW-1:0] beat_data_i,
  output logic [15:0]   fold_o,
  output logic          done_o
);
  import crc8_fold_pkg::*;

  logic [CW-1:0] cnt_eff;
  fold_t         lane_prod [LANES];
  fold_t         carry_prod;
  fold_t         fold_nxt;
  fold_t         acc_q, res_q;
  logic          done_q;

  assign cnt_eff = (beat_count_i > CW'(LANES)) ? CW'(LANES) : beat_count_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    crc8_fold_lane #(.LANES(LANES), .LANE(k), .POLY(POLY)) u_lane (
      .count_i (cnt_eff),
      .byte_i  (beat_data_i[8*k +: 8]),
      .prod_o  (lane_prod[k])
    );
  end

  crc8_fold_carry #(.LANES(LANES), .POLY(POLY)) u_carry (
    .count_i (cnt_eff),
    .fold_i  (acc_q),
    .prod_o  (carry_prod)
  );

  always_comb begin
    fold_nxt = carry_prod;
    for (int k = 0; k < LANES; k++) fold_nxt = fold_nxt ^ lane_prod[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= beat_valid_i && beat_last_i;
      if (beat_valid_i) begin
        if (beat_last_i) begin
          res_q <= fold_nxt;
          acc_q <= '0;
        end else begin
          acc_q <= fold_nxt;
        end
      end
    end
  end

  assign fold_o = res_q;
  assign done_o = done_q;
endmodule

// File: rtl/crc8_fold_acc_chk.sv
module crc8_fold_acc_chk #(
  parameter int  LANES = 8,
  localparam int CW    = $clog2(LANES + 1),
  localparam int DW    = 8 * LANES
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          beat_valid_i,
  input logic          beat_last_i,
  input logic [CW-1:0] beat_count_i,
  input logic [DW-1:0] beat_data_i,
  input logic [15:0]   fold_o,
  input logic          done_o
);
  logic in_msg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_msg_q <= 1'b0;
    else if (beat_valid_i) in_msg_q <= !beat_last_i;
  end

  // R3
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == $past(beat_valid_i && beat_last_i));

  // R4
  fold_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> fold_o == $past(fold_o));

  // R10
  zero_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_last_i && !in_msg_q && beat_data_i == '0) |=> fold_o == 16'h0);

  // R10
  one_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_last_i && !in_msg_q && beat_count_i == CW'(1))
    |=> fold_o == {8'h00, $past(beat_data_i[7:0])});

  // R7
  empty_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_last_i && !in_msg_q && beat_count_i == '0) |=> fold_o == 16'h0);
endmodule

bind crc8_fold_acc crc8_fold_acc_chk #(.LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_valid_i (beat_valid_i),
  .beat_last_i  (beat_last_i),
  .beat_count_i (beat_count_i),
  .beat_data_i  (beat_data_i),
  .fold_o       (fold_o),
  .done_o       (done_o)
);

// File: tb/tb_crc8_fold_acc.sv
module tb_crc8_fold_acc;
  localparam int CLK_PERIOD = 10;
  localparam int NTV = 6;

  // data, count, expected fold
  localparam logic [63:0] TV_DATA [NTV] = '{
    64'h3837_3635_3433_3231, 64'hFFFF_FFFF_FFFF_FFA5, 64'hEEEE_EEEE_EEEE_0705,
    64'h0000_0000_0000_0000, 64'hDEAD_BEEF_1234_5678, 64'h3837_3635_3433_3231};
  localparam logic [3:0]  TV_CNT  [NTV] = '{4'd8, 4'd1, 4'd2, 4'd8, 4'd0, 4'd12};
  localparam logic [15:0] TV_FOLD [NTV] = '{16'h1137, 16'h00A5, 16'h001C, 16'h0000, 16'h0000, 16'h1137};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic beat_valid_i = 1'b0, beat_last_i = 1'b0;
  logic [3:0] beat_count_i = '0;
  logic [63:0] beat_data_i = '0;
  logic [15:0] fold_o;
  logic done_o;
  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crc8_fold_acc dut (.*);

  function automatic logic [7:0] reduce(input logic [15:0] f);
    logic [23:0] r;
    r = {f, 8'h00};
    for (int i = 23; i >= 8; i--) if (r[i]) r = r ^ (24'h107 << (i - 8));
    return r[7:0];
  endfunction

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [63:0] d, input logic [3:0] c, input logic l, output logic dn);
    @(negedge clk_i);
    beat_valid_i = 1'b1; beat_data_i = d; beat_count_i = c; beat_last_i = l;
    @(negedge clk_i);
    beat_valid_i = 1'b0; beat_last_i = 1'b0;
    beat_data_i = {$urandom, $urandom};
    dn = done_o;
  endtask

  task automatic idle_junk(output logic dn);
    @(negedge clk_i);
    beat_valid_i = 1'b0; beat_last_i = 1'b1; beat_count_i = 4'd8;
    beat_data_i = {$urandom, $urandom};
    @(negedge clk_i);
    beat_last_i = 1'b0;
    dn = done_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic dn;
    logic [15:0] held;
    logic [7:0] msg [40];
    repeat (3) @(negedge clk_i);
    check("R1 fold reset", fold_o, 0);
    check("R1 done reset", done_o, 0);
    rst_ni = 1'b1;

    // R2 R6 R7 R10 vector table
    for (int t = 0; t < NTV; t++) begin
      beat(TV_DATA[t], TV_CNT[t], 1'b1, dn);
      check("R3 done after last", dn, 1);
      check("R2/R6/R7/R10 fold", fold_o, TV_FOLD[t]);
      @(negedge clk_i);
      check("R3 single pulse", done_o, 0);
    end

    // R5 known CRCs
    beat(64'h0705, 4'd2, 1'b1, dn);
    check("R5 crc 05 07", reduce(fold_o), 8'h54);
    beat(64'hFF_FF_FF_35_34_33_32_31, 4'd5, 1'b0, dn);
    check("R3 no done mid", dn, 0);
    held = fold_o;
    check("R4 hold mid msg", fold_o, held);
    beat(64'hAA_AA_AA_AA_AA_38_37_36, 4'd3, 1'b1, dn);
    check("R5 split 5+3", reduce(fold_o), 8'hC7);

    // R7 count 0 mid message, R8 junk idle with last
    beat(64'h0000_0000_0000_3231, 4'd2, 1'b0, dn);
    beat(64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 1'b0, dn);
    idle_junk(dn);
    check("R8 no done on idle", dn, 0);
    beat(64'h0000_0000_0000_3433, 4'd2, 1'b1, dn);
    check("R7/R8 crc unchanged",
          reduce(fold_o), crc_step(crc_step(crc_step(crc_step(8'h0, 8'h31), 8'h32), 8'h33), 8'h34));

    // R4 hold over idle
    held = fold_o;
    repeat (5) idle_junk(dn);
    check("R4 hold idle", fold_o, held);

    // R9 back to back messages
    beat(64'h1234_5678_9ABC_DEF0, 4'd8, 1'b0, dn);
    beat(64'h0000_0000_0000_00A5, 4'd8, 1'b1, dn);
    beat(64'hFFFF_FFFF_FFFF_FF5A, 4'd1, 1'b1, dn);
    check("R9 restart", fold_o, 16'h005A);

    // R5 R6 random messages
    for (int m = 0; m < 150; m++) begin
      int len, pos;
      logic [7:0] crc;
      len = 1 + $urandom_range(39);
      crc = 8'h00;
      for (int i = 0; i < len; i++) begin
        msg[i] = 8'($urandom);
        crc = crc_step(crc, msg[i]);
      end
      pos = 0;
      while (pos < len) begin
        int n;
        logic [63:0] d;
        n = 1 + $urandom_range(7);
        if (n > len - pos) n = len - pos;
        d = {$urandom, $urandom};
        for (int k = 0; k < n; k++) d[8*k +: 8] = msg[pos + k];
        if ($urandom_range(3) == 0) idle_junk(dn);
        beat(d, 4'(n), (pos + n) == len, dn);
        pos += n;
        if (pos < len && dn) begin
          n_chk++; n_fail++;
          $display("FAIL R3 act=1 exp=0");
        end
      end
      check("R5 random crc", {dn, reduce(fold_o)}, {1'b1, crc});
    end

    // R1 reset mid run
    beat(64'h0000_0000_0000_0077, 4'd1, 1'b1, dn);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 fold cleared", fold_o, 0);
    check("R1 done cleared", done_o, 0);
    rst_ni = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule